// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a memory array that two independent ports can reach at once. On every clock it compares the two ports' enables and addresses. When both ports select the same location, it lets one of them through and pulls the other port's active-low busy line. The losing port's write strobe is held off for as long as its busy is asserted. Arbitration uses only enable and address. Whether either port is reading or writing plays no part in the decision.

A mode input picks the role. In master mode the block does the arbitration itself and drives both busy outputs. In slave mode no arbitration takes place. Each port instead has a busy input from an external master, and a low level there suppresses that port's writes. The busy outputs stay high in slave mode. This lets several copies share one decision when the array is made wider.

The busy decision is registered, so a port has to present its address one cycle before it drives its write strobe. This is the same address-before-write rule a master/slave array needs. A registered collision flag goes high whenever either busy output is low, so the system can count an illegal collision as an event.

Top module: `dp_collide_arb`

## Requirements
- R1: In master mode, if either enable is low or the two addresses differ in the cycle sampled at a clock edge, both `a_busy_n` and `b_busy_n` are high after that edge. After any edge sampled in slave mode, both are also high.
- R2: The `a_wr` and `b_wr` levels have no effect on which port gets busy. Two reads that collide produce the same busy pattern as two writes that collide.
- R3: When a new collision forms, the loser is the port that arrived later. A port counts as arrived earlier if it was enabled with the same address at the previous edge and the other port was not. The later port's busy goes low at the edge after the colliding cycle.
- R4: When neither port, or both ports, held their address from the previous edge, parameter `TIE_A_WINS` decides. With the default of 1, port A wins and `b_busy_n` goes low. The two busy outputs are never low together.
- R5: In master mode, `x_wr_ok = x_en & x_wr & x_busy_n`. The level on `x_busy_in_n` is ignored in this mode.
- R6: In slave mode, `x_wr_ok = x_en & x_wr & x_busy_in_n`. It responds in the same cycle, once the busy register has cleared. No arbitration takes place, and the busy outputs stay high.
- R7: The address compare covers all `AW` bits (14 by default, 13 for the half-depth build). Addresses that differ only in the top bit are not a collision.
- R8: Busy is released at the first edge after the match ends. The formerly blocked port's write passes from the following cycle onward.
- R9: `collide` is a registered output that is high exactly when `a_busy_n` or `b_busy_n` is low. It is low after reset.
- R10: Reset (`rst_n` low, asynchronous) sets both busy outputs high and `collide` low.
- R11: While a collision persists in master mode, the same port keeps busy. Busy never swaps over to the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy; 0 = external busy inputs inhibit writes |
| a_en | input | 1 | Port A enable |
| a_addr | input | AW | Port A address |
| a_wr | input | 1 | Port A write request |
| b_en | input | 1 | Port B enable |
| b_addr | input | AW | Port B address |
| b_wr | input | 1 | Port B write request |
| a_busy_in_n | input | 1 | Port A external write inhibit, active low (slave mode) |
| b_busy_in_n | input | 1 | Port B external write inhibit, active low (slave mode) |
| a_busy_n | output | 1 | Port A busy, active low |
| b_busy_n | output | 1 | Port B busy, active low |
| a_wr_ok | output | 1 | Gated write strobe for port A |
| b_wr_ok | output | 1 | Gated write strobe for port B |
| collide | output | 1 | Registered collision flag |

## Verification
The bench builds staggered arrivals from each side in turn. A design that always favoured one fixed port, or that judged arrival from the write level, would give busy to the wrong port. Simultaneous arrivals check that exactly one port loses. A collision held for several cycles, with the winner writing, catches a design that swaps busy over mid-collision. Addresses that differ only in the top bit expose a compare that is too narrow. A low external busy level in master mode, and a collision in slave mode, show whether the two roles have leaked into each other. A long random run over a four-word address space is compared against a behavioural model on every cycle.

// File: rtl/dp_collide_arb.sv
module dp_collide_arb #(
  parameter int AW         = 14,
  parameter bit TIE_A_WINS = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  input  logic          a_wr,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  input  logic          b_wr,
  input  logic          a_busy_in_n,
  input  logic          b_busy_in_n,
  output logic          a_busy_n,
  output logic          b_busy_n,
  output logic          a_wr_ok,
  output logic          b_wr_ok,
  output logic          collide
);

  logic          busy_a_q, busy_b_q, collide_q;
  logic          a_en_q, b_en_q;
  logic [AW-1:0] a_addr_q, b_addr_q;
  logic          same, a_held, b_held, lose_a, lose_b;

  assign same   = a_en & b_en & (a_addr == b_addr);
  assign a_held = a_en_q & (a_addr_q == a_addr);
  assign b_held = b_en_q & (b_addr_q == b_addr);

  always_comb begin
    lose_a = 1'b0;
    lose_b = 1'b0;
    if (master_mode && same) begin
      if (busy_a_q)                lose_a = 1'b1;
      else if (busy_b_q)           lose_b = 1'b1;
      else if (a_held && !b_held)  lose_b = 1'b1;
      else if (b_held && !a_held)  lose_a = 1'b1;
      else if (TIE_A_WINS)         lose_b = 1'b1;
      else                         lose_a = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_a_q  <= 1'b0;
      busy_b_q  <= 1'b0;
      collide_q <= 1'b0;
      a_en_q    <= 1'b0;
      b_en_q    <= 1'b0;
      a_addr_q  <= '0;
      b_addr_q  <= '0;
    end else begin
      busy_a_q  <= lose_a;
      busy_b_q  <= lose_b;
      collide_q <= lose_a | lose_b;
      a_en_q    <= a_en;
      b_en_q    <= b_en;
      a_addr_q  <= a_addr;
      b_addr_q  <= b_addr;
    end
  end

  assign a_busy_n = ~busy_a_q;
  assign b_busy_n = ~busy_b_q;
  assign collide  = collide_q;
  assign a_wr_ok  = a_en & a_wr & ~busy_a_q & (master_mode | a_busy_in_n);
  assign b_wr_ok  = b_en & b_wr & ~busy_b_q & (master_mode | b_busy_in_n);

endmodule

module dp_collide_arb_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_mode,
  input logic          a_en,
  input logic [AW-1:0] a_addr,
  input logic          b_en,
  input logic [AW-1:0] b_addr,
  input logic          a_busy_in_n,
  input logic          b_busy_in_n,
  input logic          a_busy_n,
  input logic          b_busy_n,
  input logic          a_wr_ok,
  input logic          b_wr_ok,
  input logic          collide
);
  logic hit;
  assign hit = a_en && b_en && (a_addr == b_addr);

  a_r4_never_both_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(!a_busy_n && !b_busy_n));

  a_r1_release_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode || !hit) |=> (a_busy_n && b_busy_n));

  a_r5_a_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !a_busy_n |-> !a_wr_ok);

  a_r5_b_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !b_busy_n |-> !b_wr_ok);

  a_r6_slave_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && (!a_busy_in_n || !b_busy_in_n)) |->
      ((a_busy_in_n || !a_wr_ok) && (b_busy_in_n || !b_wr_ok)));

  a_r9_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
    collide == (!a_busy_n || !b_busy_n));

  a_r11_keep_loser: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && hit && !a_busy_n) |=> !a_busy_n);
endmodule

bind dp_collide_arb dp_collide_arb_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
  .a_en(a_en), .a_addr(a_addr), .b_en(b_en), .b_addr(b_addr),
  .a_busy_in_n(a_busy_in_n), .b_busy_in_n(b_busy_in_n),
  .a_busy_n(a_busy_n), .b_busy_n(b_busy_n),
  .a_wr_ok(a_wr_ok), .b_wr_ok(b_wr_ok), .collide(collide)
);

// File: tb/dp_collide_arb_tb.sv
`timescale 1ns/1ps
module dp_collide_arb_tb_top;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mst = 1'b1, ain = 1'b1, bin = 1'b1;
  logic aen = 1'b0, awr = 1'b0, ben = 1'b0, bwr = 1'b0;
  logic [AW-1:0] aad = '0, bad_ad = '0;
  logic abn, bbn, aok, bok, col;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dp_collide_arb #(.AW(AW), .TIE_A_WINS(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .master_mode(mst),
    .a_en(aen), .a_addr(aad), .a_wr(awr),
    .b_en(ben), .b_addr(bad_ad), .b_wr(bwr),
    .a_busy_in_n(ain), .b_busy_in_n(bin),
    .a_busy_n(abn), .b_busy_n(bbn), .a_wr_ok(aok), .b_wr_ok(bok), .collide(col)
  );

  // behavioural reference: who is blocked, remembered across edges
  int m_loser = 0;            // 0 none, 1 = A blocked, 2 = B blocked
  int pa = -1, pb = -1;       // previous enabled address, -1 when idle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_loser = 0; pa = -1; pb = -1;
    end else begin
      int ca, cb, nxt;
      ca = aen ? int'(aad) : -1;
      cb = ben ? int'(bad_ad) : -1;
      nxt = 0;
      if (mst && ca >= 0 && ca == cb) begin
        if (m_loser != 0) nxt = m_loser;
        else if (pa == ca && pb != cb) nxt = 2;
        else if (pb == cb && pa != ca) nxt = 1;
        else nxt = 2;
      end
      m_loser = nxt; pa = ca; pb = cb;
    end
  end

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s at %0t: got %0d expected %0d", req, $time, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    int ea, eb;
    chk("R4 busy_a vs model", abn, m_loser != 1);
    chk("R3 busy_b vs model", bbn, m_loser != 2);
    chk("R9 flag vs model", col, m_loser != 0);
    ea = aen && awr && m_loser != 1 && (mst || ain);
    eb = ben && bwr && m_loser != 2 && (mst || bin);
    chk("R5 a_wr_ok vs model", aok, ea);
    chk("R6 b_wr_ok vs model", bok, eb);
  end

  task automatic cyc(bit ae, int aa, bit aw, bit be, int ba, bit bw);
    @(posedge clk); #1;
    aen = ae; aad = AW'(aa); awr = aw;
    ben = be; bad_ad = AW'(ba); bwr = bw;
    @(negedge clk); #1;
  endtask

  initial begin
    #200_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    chk("R10 reset busy_a", abn, 1);
    chk("R10 reset busy_b", bbn, 1);
    chk("R10 reset collide", col, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 different addresses, both writing
    cyc(1, 16'h0010, 1, 1, 16'h0020, 1);
    cyc(1, 16'h0010, 1, 1, 16'h0020, 1);
    chk("R1 no match busy_a", abn, 1);
    chk("R1 no match busy_b", bbn, 1);
    chk("R1 no match writes", aok & bok, 1);

    // R3 A first, B later collides
    cyc(1, 16'h0100, 0, 0, 0, 0);
    cyc(1, 16'h0100, 0, 1, 16'h0100, 1);
    cyc(1, 16'h0100, 0, 1, 16'h0100, 1);
    chk("R3 later B busy", bbn, 0);
    chk("R3 earlier A free", abn, 1);
    chk("R5 B write blocked", bok, 0);
    chk("R9 collide high", col, 1);
    cyc(1, 16'h0100, 1, 1, 16'h0100, 1);
    chk("R11 loser kept", bbn, 0);
    chk("R2 winner write passes", aok, 1);
    // R8 B leaves
    cyc(1, 16'h0100, 0, 1, 16'h0101, 1);
    chk("R8 still blocked this cycle", bok, 0);
    cyc(1, 16'h0100, 0, 1, 16'h0101, 1);
    chk("R8 busy released", bbn, 1);
    chk("R8 write proceeds", bok, 1);
    chk("R9 collide low", col, 0);

    // R4 simultaneous arrival, both reads
    cyc(1, 16'h0011, 0, 1, 16'h0022, 0);
    cyc(1, 16'h002A, 0, 1, 16'h002A, 0);
    cyc(1, 16'h002A, 0, 1, 16'h002A, 0);
    chk("R4 tie A wins", abn, 1);
    chk("R4 tie B busy", bbn, 0);
    chk("R2 reads still arbitrated", col, 1);

    // R3 B first, A later
    cyc(0, 0, 0, 1, 16'h0033, 0);
    cyc(1, 16'h0033, 1, 1, 16'h0033, 0);
    cyc(1, 16'h0033, 1, 1, 16'h0033, 0);
    chk("R3 later A busy", abn, 0);
    chk("R5 A write blocked", aok, 0);
    cyc(1, 16'h0033, 1, 1, 16'h0033, 1);
    chk("R11 A stays loser", abn, 0);
    chk("R11 B not swapped", bbn, 1);

    // R7 top bit only differs
    cyc(1, 16'h0005, 1, 1, 16'h2005, 1);
    cyc(1, 16'h0005, 1, 1, 16'h2005, 1);
    chk("R7 msb differs busy_a", abn, 1);
    chk("R7 msb differs busy_b", bbn, 1);

    // R1 one enable low
    cyc(1, 16'h0040, 1, 0, 16'h0040, 1);
    cyc(1, 16'h0040, 1, 0, 16'h0040, 1);
    chk("R1 disabled peer", abn & bbn, 1);

    // R5 busy input ignored in master mode
    ain = 1'b0;
    cyc(1, 16'h0060, 1, 1, 16'h0070, 1);
    chk("R5 pin ignored in master", aok, 1);

    // R6 slave mode
    mst = 1'b0;
    cyc(1, 16'h0050, 1, 1, 16'h0050, 1);
    chk("R6 slave A inhibited", aok, 0);
    chk("R6 slave B passes", bok, 1);
    cyc(1, 16'h0050, 1, 1, 16'h0050, 1);
    chk("R6 slave no busy", abn & bbn, 1);
    chk("R6 slave no collide", col, 0);
    ain = 1'b1; bin = 1'b0;
    cyc(1, 16'h0050, 1, 1, 16'h0050, 1);
    chk("R6 slave B inhibited", bok, 0);
    chk("R6 slave A passes", aok, 1);
    bin = 1'b1; mst = 1'b1;

    // random master traffic over four words
    for (int i = 0; i < 400; i++) begin
      ain = 1'($urandom); bin = 1'($urandom);
      cyc(1'($urandom), int'($urandom % 4), 1'($urandom),
          1'($urandom), int'($urandom % 4), 1'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule